// File: doc/BRIEF.md
# Lane-Partitioned 48-bit Adder/Subtractor

This block is a registered 48-bit adder/subtractor whose carry chain can be cut into independent lanes. One operand is built by joining a 30-bit upper input and an 18-bit lower input into a single 48-bit word X. The other operand is a separate 48-bit word Z. A lane-mode input picks one of three layouts: one 48-bit lane, two 24-bit lanes or four 12-bit lanes. An operation input picks one of two operations, Z + X or Z − X, and the choice applies to every lane at once.

Each lane drives its own carry-out bit, which serves as the extra high bit of that lane's sum. A datapath can therefore pack several narrow additions or subtractions into one wide unit. A lane that is not in use is fed zero operands and stays silent. The result and the carry vector are registered and appear one clock after the inputs.

Top module: `simd_addsub`

## Requirements
- R1: While rst_n is low at a rising clock edge, `result` and `carry_out` are cleared to zero at that edge.
- R2: `result` and `carry_out` reflect the inputs sampled at the previous rising edge. Input changes between edges do not affect the outputs.
- R3: X is `{a_hi, b_lo}`, so `a_hi` supplies bits 47:18 and `b_lo` supplies bits 17:0. With `sub_en` = 0, each lane's result is (Z + X) modulo 2^lane width, where Z is `c_in`.
- R4: With `sub_en` = 1, each lane's result is (Z − X) modulo 2^lane width, formed as Z + ~X + 1 inside the lane.
- R5: `lane_mode` = 2'b10 selects four 12-bit lanes. `carry_out[k]` is the carry out of bits 12k+11:12k.
- R6: `lane_mode` = 2'b01 selects two 24-bit lanes. `carry_out[1]` is the carry of bits 23:0 and `carry_out[3]` is the carry of bits 47:24. Bits 0 and 2 read zero.
- R7: `lane_mode` = 2'b00 or 2'b11 selects one 48-bit lane. The carry runs through all 48 bits, `carry_out[3]` is the final carry, and bits 2:0 read zero.
- R8: No carry crosses a lane boundary. A lane that overflows, for example all ones plus one, leaves the neighbouring lane's result unchanged.
- R9: In subtract mode, a lane's carry bit is 1 when that lane's Z is greater than or equal to its X as unsigned numbers (no borrow), and 0 otherwise.
- R10: A lane whose X and Z are both zero gives a zero result. Its carry is 0 when adding and 1 when subtracting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| a_hi | input | 30 | Upper part of operand X (bits 47:18) |
| b_lo | input | 18 | Lower part of operand X (bits 17:0) |
| c_in | input | 48 | Operand Z |
| lane_mode | input | 2 | 00/11 one lane, 01 two lanes, 10 four lanes |
| sub_en | input | 1 | 0 = Z + X, 1 = Z − X |
| result | output | 48 | Registered lane results |
| carry_out | output | 4 | Registered per-lane carry bits |

## Verification
The assertions check four things on every cycle. In two-lane and one-lane modes, the carry bits that are not used stay zero. Subtracting equal operands gives zero. Adding zero operands gives zero result and zero carry. The per-lane arithmetic itself, the independence of the lanes at their boundaries and the borrow convention can only be shown by the bench. It sweeps every mode and operation with all-ones, boundary and random operands and compares each lane against a model built from lane widths. The bench also shows the one-cycle latency and the reset clear.

// File: rtl/simd_pkg.sv
// Shared types for the lane-partitioned adder.
// Assumes: lane mode is a 2-bit code; the reserved code acts as one lane.
package simd_pkg;
    typedef enum logic [1:0] {
        LM_ONE48  = 2'b00,
        LM_TWO24  = 2'b01,
        LM_FOUR12 = 2'b10,
        LM_RSVD   = 2'b11
    } lane_mode_e;
endpackage

// File: rtl/simd_seg.sv
// One carry segment of the datapath: sum = z + (x ^ inv) + cin.
// Assumes: the caller supplies cin (lane start or chained carry).
module simd_seg #(
    parameter int SEG = 12
) (
    input  logic [SEG-1:0] x_in,
    input  logic [SEG-1:0] z_in,
    input  logic           inv,
    input  logic           cin,
    output logic [SEG-1:0] sum,
    output logic           cout
);
    logic [SEG-1:0] x_eff;

    // Conditionally invert X for the subtract form.
    always_comb x_eff = x_in ^ {SEG{inv}};

    // Segment adder with carry in and carry out.
    always_comb {cout, sum} = {1'b0, z_in} + {1'b0, x_eff} + {{SEG{1'b0}}, cin};
endmodule

// File: rtl/simd_lane_ctl.sv
// Decodes the lane mode into per-segment lane-start and lane-end flags.
// Assumes: NSEG is even, so two-lane mode splits at NSEG/2 segments.
module simd_lane_ctl import simd_pkg::*; #(
    parameter int NSEG = 4
) (
    input  lane_mode_e      mode,
    output logic [NSEG-1:0] lane_start,
    output logic [NSEG-1:0] lane_end
);
    localparam int HALF = NSEG / 2;

    for (genvar k = 0; k < NSEG; k++) begin : g_flag
        // Segment k opens a lane when the mode places a boundary below it.
        always_comb begin
            unique case (mode)
                LM_FOUR12: lane_start[k] = 1'b1;
                LM_TWO24:  lane_start[k] = ((k % HALF) == 0);
                default:   lane_start[k] = (k == 0);
            endcase
        end
        // Segment k closes a lane when the mode places a boundary above it.
        always_comb begin
            unique case (mode)
                LM_FOUR12: lane_end[k] = 1'b1;
                LM_TWO24:  lane_end[k] = ((k % HALF) == HALF - 1);
                default:   lane_end[k] = (k == NSEG - 1);
            endcase
        end
    end
endmodule

// File: rtl/simd_addsub.sv
// Registered lane-partitioned adder/subtractor: result = Z +/- {a_hi,b_lo}
// per lane, with carries cut at lane boundaries and one carry bit per lane.
// Assumes: W is a multiple of SEG; outputs cleared by synchronous active-low reset.
module simd_addsub import simd_pkg::*; #(
    parameter int W   = 48,
    parameter int SEG = 12,
    parameter int AW  = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      a_hi,
    input  logic [W-AW-1:0]    b_lo,
    input  logic [W-1:0]       c_in,
    input  logic [1:0]         lane_mode,
    input  logic               sub_en,
    output logic [W-1:0]       result,
    output logic [W/SEG-1:0]   carry_out
);
    localparam int NSEG = W / SEG;

    lane_mode_e      mode;
    logic [W-1:0]    op_x;
    logic [NSEG-1:0] lane_start;
    logic [NSEG-1:0] lane_end;
    logic [NSEG-1:0] seg_cin;
    logic [NSEG-1:0] seg_cout;
    logic [W-1:0]    nxt_sum;
    logic [NSEG-1:0] nxt_carry;

    // Decode mode and assemble the joined operand.
    always_comb begin
        mode = lane_mode_e'(lane_mode);
        op_x = {a_hi, b_lo};
    end

    simd_lane_ctl #(.NSEG(NSEG)) u_ctl (
        .mode       (mode),
        .lane_start (lane_start),
        .lane_end   (lane_end)
    );

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        if (k == 0) begin : g_first
            // First segment always starts a lane.
            always_comb seg_cin[k] = sub_en;
        end else begin : g_rest
            // Start a fresh lane or chain from the segment below.
            always_comb seg_cin[k] = lane_start[k] ? sub_en : seg_cout[k-1];
        end
        simd_seg #(.SEG(SEG)) u_seg (
            .x_in (op_x[k*SEG +: SEG]),
            .z_in (c_in[k*SEG +: SEG]),
            .inv  (sub_en),
            .cin  (seg_cin[k]),
            .sum  (nxt_sum[k*SEG +: SEG]),
            .cout (seg_cout[k])
        );
    end

    // Report only carries leaving a lane.
    always_comb nxt_carry = seg_cout & lane_end;

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            carry_out <= '0;
        end else begin
            result    <= nxt_sum;
            carry_out <= nxt_carry;
        end
    end

    // R6: unused carry bits in two-lane mode read zero.
    assert_two_lane_dc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode == 2'b01) |=> (carry_out[0] == 1'b0 && carry_out[2] == 1'b0));

    // R7: one-lane mode leaves the low carry bits at zero.
    assert_one_lane_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode == 2'b00 || lane_mode == 2'b11) |=> (carry_out[NSEG-2:0] == '0));

    // R4: subtracting equal operands yields zero in every lane.
    assert_sub_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_en && c_in == {a_hi, b_lo}) |=> (result == '0));

    // R10: adding zero operands yields zero result and zero carry.
    assert_add_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_en && c_in == '0 && {a_hi, b_lo} == '0) |=> (result == '0 && carry_out == '0));
endmodule

// File: tb/tb_simd_addsub.sv
module tb_simd_addsub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] a_hi = '0;
    logic [17:0] b_lo = '0;
    logic [47:0] c_in = '0;
    logic [1:0]  lane_mode = 2'b00;
    logic        sub_en = 1'b0;
    logic [47:0] result;
    logic [3:0]  carry_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    simd_addsub dut (
        .clk(clk), .rst_n(rst_n), .a_hi(a_hi), .b_lo(b_lo), .c_in(c_in),
        .lane_mode(lane_mode), .sub_en(sub_en), .result(result), .carry_out(carry_out)
    );

    // Per-lane reference built from lane width only.
    function automatic void ref_model(input logic [1:0] m, input logic s,
                                      input logic [47:0] x, input logic [47:0] z,
                                      output logic [47:0] r, output logic [3:0] co);
        int lw;
        lw = (m == 2'b10) ? 12 : (m == 2'b01) ? 24 : 48;
        r = '0; co = '0;
        for (int o = 0; o < 48; o += lw) begin
            logic [63:0] mask, xm, zm, sm;
            mask = (64'd1 << lw) - 64'd1;
            xm = (64'(x) >> o) & mask;
            zm = (64'(z) >> o) & mask;
            sm = s ? zm + ((~xm) & mask) + 64'd1 : zm + xm;
            r  = r | 48'((sm & mask) << o);
            co[(o + lw) / 12 - 1] = sm[lw];
        end
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string res_tag(input logic [1:0] m, input logic s);
        if (s) return (m == 2'b10) ? "R4 R8 lanes12" : "R4 lanes";
        return (m == 2'b10) ? "R3 R8 lanes12" : "R3 lanes";
    endfunction

    function automatic string co_tag(input logic [1:0] m, input logic s);
        string t;
        t = (m == 2'b10) ? "R5" : (m == 2'b01) ? "R6" : "R7";
        return s ? {t, " R9 carry"} : {t, " carry"};
    endfunction

    // Drive at a falling edge, sample at the next falling edge.
    task automatic apply(input logic [1:0] m, input logic s, input logic [47:0] x, input logic [47:0] z);
        logic [47:0] er;
        logic [3:0]  ec;
        @(negedge clk);
        lane_mode = m; sub_en = s; a_hi = x[47:18]; b_lo = x[17:0]; c_in = z;
        ref_model(m, s, x, z, er, ec);
        @(negedge clk);
        check(result == er, res_tag(m, s), 64'(result), 64'(er));
        check(carry_out == ec, co_tag(m, s), 64'(carry_out), 64'(ec));
    endtask

    initial begin
        logic [47:0] er0;
        logic [3:0]  ec0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(result == '0 && carry_out == '0, "R1 reset", {12'd0, carry_out, result}, 64'd0);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                // R10: zero operands
                apply(2'(m), 1'(s), 48'd0, 48'd0);
                // R8: all ones plus one in each 12-bit lane
                apply(2'(m), 1'(s), 48'h001001001001, 48'hFFFFFFFFFFFF);
                apply(2'(m), 1'(s), 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF);
                apply(2'(m), 1'(s), 48'hFFFFFFFFFFFF, 48'h000000000001);
                // R9: equal and one-off operands across lane boundaries
                apply(2'(m), 1'(s), 48'h800800800800, 48'h800800800800);
                apply(2'(m), 1'(s), 48'h000001000001, 48'h000000000000);
                apply(2'(m), 1'(s), 48'h000000000001, 48'h001000001000);
                for (int i = 0; i < 300; i++) begin
                    logic [47:0] rx, rz;
                    rx = {$urandom, $urandom} ;
                    rz = {$urandom, $urandom};
                    if (i % 7 == 0) rz = rx;
                    apply(2'(m), 1'(s), rx, rz);
                end
            end
        end

        // R2: outputs hold until the next rising edge
        apply(2'b10, 1'b0, 48'h123456789ABC, 48'h0F0F0F0F0F0F);
        ref_model(2'b10, 1'b0, 48'h123456789ABC, 48'h0F0F0F0F0F0F, er0, ec0);
        c_in = 48'hFFFFFFFFFFFF; sub_en = 1'b1;
        #2;
        check(result == er0 && carry_out == ec0, "R2 hold", 64'(result), 64'(er0));

        // R1: mid-run reset clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(result == '0 && carry_out == '0, "R1 midrun", {12'd0, carry_out, result}, 64'd0);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule